// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits behind the receive path of an Ethernet MAC and decides, frame by frame, whether a frame goes on to the application or is dropped. It watches the first sixteen header octets as they arrive one octet per valid cycle: six octets of destination address, six of source address, two of type and two of opcode. It matches them against a programmed station address and a small table of source-address entries, then applies a 32-bit filter configuration word.

For each frame whose header completes, it raises a one-cycle result strobe. The strobe carries the pass/drop verdict, a destination-fail flag, a source-fail flag and two classification flags, one for control frames and one for pause frames. The modes interact with a fixed precedence. A blocked broadcast loses to nothing. Receive-all comes next. Control frames then follow their own four-way forwarding policy. All other frames follow the address filter, which promiscuous mode opens fully. The flow-control inputs only affect pause classification.

Top module: `rxf_addr_filter`

## Requirements
- R1: Octets are taken when `hdr_vld` is 1, and `hdr_sof` marks octet 0 of the destination address. The result strobe `res_vld` is high for exactly one cycle: the cycle after the sixteenth header octet is sampled. A header cut short by a new `hdr_sof` gives no strobe, idle gaps inside a header are allowed, and octets after the header give no further strobe.
- R2: In normal filtering, a destination equal to `stn_addr` passes. Any other unicast destination sets `res_da_fail` and is dropped. Addresses are packed with octet 0 in bits 47:40.
- R3: With configuration bit 3 set, the destination comparison is inverted for unicast and multicast destinations alike: a match fails and a mismatch passes.
- R4: A destination is multicast when bit 0 of octet 0 (bit 40 of the packed address) is 1. With configuration bit 4 set, every multicast destination passes the destination check.
- R5: The all-ones broadcast destination passes the destination check. With configuration bit 5 set, a broadcast frame is dropped even when promiscuous or receive-all is set.
- R6: Source entry i occupies `sa_tbl[48*i+47:48*i]` and is compared only when `sa_tbl_en[i]` is 1. When configuration bit 8 is clear, `res_sa_fail` is set if no enabled entry matches. When bit 8 is set, `res_sa_fail` is set if an enabled entry matches.
- R7: With configuration bit 9 set, a frame that fails the source check is dropped. With bit 9 clear, the source result only shows in `res_sa_fail`.
- R8: With configuration bit 0 (promiscuous) set, every frame passes the address filter, and both fail flags read 0.
- R9: With configuration bit 31 set, every frame except a blocked broadcast is passed, including control frames under policy 00. The fail flags still show the real comparison outcome.
- R10: A frame with type 0x8808 raises `res_ctl`. For such frames, configuration bits 7:6 select the policy. 00 drops the frame. 01 passes it unless it is a pause frame. 10 passes it. 11 passes it only if it passes the address filter.
- R11: `res_pause` is 1 only when all of the following hold: the frame is a control frame, its opcode is 0x0001, `link_fdx` is 1 and `rx_fc_en` is 1. In addition, the destination must be 01-80-C2-00-00-01, or it must equal `stn_addr` while `ucast_pause_en` is 1.
- R12: When `res_vld` is 0, all five result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_sof | input | 1 | Marks the first destination octet of a frame |
| hdr_vld | input | 1 | Octet on `hdr_byte` is valid this cycle |
| hdr_byte | input | 8 | Header octet stream |
| filt_cfg | input | 32 | Filter configuration word |
| stn_addr | input | 48 | Station address, octet 0 in bits 47:40 |
| sa_tbl | input | 48*NUM_SA | Source-address entries, entry 0 in the low bits |
| sa_tbl_en | input | NUM_SA | Per-entry compare enables |
| link_fdx | input | 1 | Link is full duplex |
| rx_fc_en | input | 1 | Receive flow control enabled |
| ucast_pause_en | input | 1 | Accept pause frames sent to the station address |
| res_vld | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Frame is forwarded |
| res_da_fail | output | 1 | Destination check failed |
| res_sa_fail | output | 1 | Source check failed |
| res_ctl | output | 1 | Frame is a control frame |
| res_pause | output | 1 | Frame is a pause frame |

## Verification
The result outputs are combinational from the captured header and the live configuration, flow-control and table inputs. The assertions that tie configuration bits to the verdict therefore assume these inputs stay steady from the first header octet through the result strobe. The stimulus changes them only while the filter is idle, two cycles after each result, and drives `hdr_sof` only together with `hdr_vld`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned OCTET_W      = 8;
  localparam int unsigned MAC_OCTETS   = 6;
  localparam int unsigned MAC_W        = MAC_OCTETS * OCTET_W;
  localparam int unsigned ETYPE_OCTETS = 2;
  localparam int unsigned OPC_OCTETS   = 2;
  localparam int unsigned HDR_OCTETS   = 2 * MAC_OCTETS + ETYPE_OCTETS + OPC_OCTETS;
  localparam int unsigned HDR_W        = HDR_OCTETS * OCTET_W;
  localparam int unsigned GROUP_BIT    = MAC_W - OCTET_W;

  localparam int unsigned CFG_W        = 32;
  localparam int unsigned CB_PROMISC   = 0;
  localparam int unsigned CB_DA_INV    = 3;
  localparam int unsigned CB_MC_ALL    = 4;
  localparam int unsigned CB_BC_BLOCK  = 5;
  localparam int unsigned CB_CTL_LO    = 6;
  localparam int unsigned CB_SA_INV    = 8;
  localparam int unsigned CB_SA_DROP   = 9;
  localparam int unsigned CB_RX_ALL    = 31;

  localparam logic [15:0]      CTL_ETYPE = 16'h8808;
  localparam logic [15:0]      PAUSE_OPC = 16'h0001;
  localparam logic [MAC_W-1:0] PAUSE_MC  = 48'h0180_C200_0001;
  localparam logic [MAC_W-1:0] BCAST     = '1;

  typedef enum logic [1:0] {
    CTL_DROP_ALL     = 2'b00,
    CTL_FWD_NO_PAUSE = 2'b01,
    CTL_FWD_ALL      = 2'b10,
    CTL_FWD_FILTERED = 2'b11
  } ctl_policy_e;

  typedef struct packed {
    logic        promisc;
    logic        da_inv;
    logic        mc_all;
    logic        bc_block;
    logic        sa_inv;
    logic        sa_drop;
    logic        rx_all;
    ctl_policy_e ctl;
  } filt_cfg_t;

  typedef struct packed {
    logic [MAC_W-1:0] da;
    logic [MAC_W-1:0] sa;
    logic [15:0]      etype;
    logic [15:0]      opc;
  } hdr_t;

  typedef struct packed {
    logic pass;
    logic da_fail;
    logic sa_fail;
    logic ctl;
    logic pause;
  } verdict_t;

  function automatic filt_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    filt_cfg_t c;
    c.promisc  = w[CB_PROMISC];
    c.da_inv   = w[CB_DA_INV];
    c.mc_all   = w[CB_MC_ALL];
    c.bc_block = w[CB_BC_BLOCK];
    c.sa_inv   = w[CB_SA_INV];
    c.sa_drop  = w[CB_SA_DROP];
    c.rx_all   = w[CB_RX_ALL];
    c.ctl      = ctl_policy_e'(w[CB_CTL_LO +: 2]);
    return c;
  endfunction

endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
  import rxf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  input  logic               vld,
  input  logic [OCTET_W-1:0] octet,
  output hdr_t               hdr,
  output logic               hdr_done
);

  localparam int unsigned       CNT_W    = $clog2(HDR_OCTETS + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(HDR_OCTETS);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HDR_W-1:0] shf_q, shf_d;
  logic             done_q, done_d;
  logic             shift_en;

  // next state
  always_comb begin
    shift_en = vld && (sof || (cnt_q != CNT_FULL));
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    done_d   = 1'b0;
    if (shift_en) begin
      shf_d  = {shf_q[HDR_W-OCTET_W-1:0], octet};
      cnt_d  = sof ? CNT_ONE : cnt_q + CNT_ONE;
      done_d = (cnt_d == CNT_FULL);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_FULL;
      done_q <= 1'b0;
      shf_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (shift_en) begin
        shf_q <= shf_d;
      end
    end
  end

  assign hdr      = hdr_t'(shf_q);
  assign hdr_done = done_q;

endmodule

// File: rtl/rxf_sa_match.sv
module rxf_sa_match
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SA = 4
) (
  input  logic [MAC_W-1:0]        sa,
  input  logic [NUM_SA*MAC_W-1:0] tbl,
  input  logic [NUM_SA-1:0]       tbl_en,
  output logic                    sa_hit
);

  logic [NUM_SA-1:0] lane_hit;

  for (genvar g = 0; g < NUM_SA; g++) begin : g_lane
    assign lane_hit[g] = tbl_en[g] && (tbl[g*MAC_W +: MAC_W] == sa);
  end

  assign sa_hit = |lane_hit;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  hdr_t             hdr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [MAC_W-1:0] stn,
  input  logic             sa_hit,
  input  logic             fdx,
  input  logic             fc_en,
  input  logic             up_en,
  output verdict_t         vd,
  output logic             is_bcast
);

  filt_cfg_t cfg;
  logic      is_mcast, da_hit, da_ok, sa_bad, filt_ok;
  logic      is_ctl, pause_da, is_pause, ctl_ok;
  logic      unused_cfg;

  assign unused_cfg = ^{cfg_word[CB_DA_INV-1:1], cfg_word[CB_RX_ALL-1:CB_SA_DROP+1]};

  always_comb begin
    cfg      = cfg_unpack(cfg_word);
    is_bcast = (hdr.da == BCAST);
    is_mcast = hdr.da[GROUP_BIT];
    da_hit   = (hdr.da == stn);

    if (is_bcast) begin
      da_ok = 1'b1;
    end else if (is_mcast && cfg.mc_all) begin
      da_ok = 1'b1;
    end else begin
      da_ok = da_hit ^ cfg.da_inv;
    end

    sa_bad  = cfg.sa_inv ? sa_hit : !sa_hit;
    filt_ok = cfg.promisc || (da_ok && !(cfg.sa_drop && sa_bad));

    is_ctl   = (hdr.etype == CTL_ETYPE);
    pause_da = (hdr.da == PAUSE_MC) || (up_en && da_hit);
    is_pause = is_ctl && (hdr.opc == PAUSE_OPC) && fdx && fc_en && pause_da;

    unique case (cfg.ctl)
      CTL_DROP_ALL:     ctl_ok = 1'b0;
      CTL_FWD_NO_PAUSE: ctl_ok = !is_pause;
      CTL_FWD_ALL:      ctl_ok = 1'b1;
      default:          ctl_ok = filt_ok;
    endcase

    if (is_bcast && cfg.bc_block) begin
      vd.pass = 1'b0;
    end else if (cfg.rx_all) begin
      vd.pass = 1'b1;
    end else if (is_ctl) begin
      vd.pass = ctl_ok;
    end else begin
      vd.pass = filt_ok;
    end

    vd.da_fail = !cfg.promisc && !da_ok;
    vd.sa_fail = !cfg.promisc && sa_bad;
    vd.ctl     = is_ctl;
    vd.pause   = is_pause;
  end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SA = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hdr_sof,
  input  logic                    hdr_vld,
  input  logic [7:0]              hdr_byte,
  input  logic [31:0]             filt_cfg,
  input  logic [47:0]             stn_addr,
  input  logic [NUM_SA*48-1:0]    sa_tbl,
  input  logic [NUM_SA-1:0]       sa_tbl_en,
  input  logic                    link_fdx,
  input  logic                    rx_fc_en,
  input  logic                    ucast_pause_en,
  output logic                    res_vld,
  output logic                    res_pass,
  output logic                    res_da_fail,
  output logic                    res_sa_fail,
  output logic                    res_ctl,
  output logic                    res_pause
);

  logic     rst_meta_q, rst_sync_n;
  hdr_t     hdr;
  logic     hdr_done;
  logic     sa_hit;
  logic     is_bcast;
  verdict_t vd, vd_out;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rxf_hdr_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sof      (hdr_sof),
    .vld      (hdr_vld),
    .octet    (hdr_byte),
    .hdr      (hdr),
    .hdr_done (hdr_done)
  );

  rxf_sa_match #(.NUM_SA(NUM_SA)) u_sam (
    .sa     (hdr.sa),
    .tbl    (sa_tbl),
    .tbl_en (sa_tbl_en),
    .sa_hit (sa_hit)
  );

  rxf_decide u_dec (
    .hdr      (hdr),
    .cfg_word (filt_cfg),
    .stn      (stn_addr),
    .sa_hit   (sa_hit),
    .fdx      (link_fdx),
    .fc_en    (rx_fc_en),
    .up_en    (ucast_pause_en),
    .vd       (vd),
    .is_bcast (is_bcast)
  );

  assign vd_out      = hdr_done ? vd : '0;
  assign res_vld     = hdr_done;
  assign res_pass    = vd_out.pass;
  assign res_da_fail = vd_out.da_fail;
  assign res_sa_fail = vd_out.sa_fail;
  assign res_ctl     = vd_out.ctl;
  assign res_pause   = vd_out.pause;

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_vld,
  input logic [31:0] filt_cfg,
  input logic        is_bcast,
  input logic        res_vld,
  input logic        res_pass,
  input logic        res_da_fail,
  input logic        res_sa_fail,
  input logic        res_ctl,
  input logic        res_pause
);

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  assert_strobe_after_octet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_vld) |-> $past(hdr_vld));

  assert_bcast_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && is_bcast && filt_cfg[5]) |-> !res_pass);

  assert_promisc_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && filt_cfg[0]) |-> (!res_da_fail && !res_sa_fail));

  assert_rx_all_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && filt_cfg[31] && !is_bcast) |-> res_pass);

  assert_ctl_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_ctl && !filt_cfg[31] && (filt_cfg[7:6] == 2'b00)) |-> !res_pass);

  assert_pause_is_ctl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_pause |-> res_ctl);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> ($countones({res_pass, res_da_fail, res_sa_fail, res_ctl, res_pause}) == 0));

endmodule

bind rxf_addr_filter rxf_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .hdr_vld     (hdr_vld),
  .filt_cfg    (filt_cfg),
  .is_bcast    (is_bcast),
  .res_vld     (res_vld),
  .res_pass    (res_pass),
  .res_da_fail (res_da_fail),
  .res_sa_fail (res_sa_fail),
  .res_ctl     (res_ctl),
  .res_pause   (res_pause)
);

// File: tb/test_rxf_addr_filter.sv
module test_rxf_addr_filter;

  localparam int NSA   = 4;
  localparam int LIMIT = 100000;

  localparam logic [47:0] STA   = 48'h0211_2233_4455;
  localparam logic [47:0] OTH   = 48'h02AA_BBCC_DDEE;
  localparam logic [47:0] MC    = 48'h0100_5E00_0007;
  localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] PMC   = 48'h0180_C200_0001;
  localparam logic [47:0] SA_A  = 48'h0A00_0000_0001;
  localparam logic [47:0] SA_B  = 48'h0A00_0000_0002;
  localparam logic [47:0] SA_C  = 48'h0A00_0000_0003;
  localparam logic [47:0] SA_X  = 48'h0A00_0000_0009;
  localparam logic [15:0] TIP   = 16'h0800;
  localparam logic [15:0] TCTL  = 16'h8808;

  localparam logic [31:0] C_PROM = 32'h1;
  localparam logic [31:0] C_DAI  = 32'h8;
  localparam logic [31:0] C_PAM  = 32'h10;
  localparam logic [31:0] C_DBF  = 32'h20;
  localparam logic [31:0] C_P01  = 32'h40;
  localparam logic [31:0] C_P10  = 32'h80;
  localparam logic [31:0] C_P11  = 32'hC0;
  localparam logic [31:0] C_SAI  = 32'h100;
  localparam logic [31:0] C_SAF  = 32'h200;
  localparam logic [31:0] C_RA   = 32'h8000_0000;

  logic              clk, rst_n;
  logic              hdr_sof, hdr_vld;
  logic [7:0]        hdr_byte;
  logic [31:0]       filt_cfg;
  logic [47:0]       stn_addr;
  logic [NSA*48-1:0] sa_tbl;
  logic [NSA-1:0]    sa_tbl_en;
  logic              link_fdx, rx_fc_en, ucast_pause_en;
  logic              res_vld, res_pass, res_da_fail, res_sa_fail, res_ctl, res_pause;

  typedef struct {
    bit    pass, daf, saf, ctl, pau;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   mon_on = 0;
  bit   ended  = 0;

  rxf_addr_filter #(.NUM_SA(NSA)) i_rxf_addr_filter (
    .clk(clk), .rst_n(rst_n), .hdr_sof(hdr_sof), .hdr_vld(hdr_vld), .hdr_byte(hdr_byte),
    .filt_cfg(filt_cfg), .stn_addr(stn_addr), .sa_tbl(sa_tbl), .sa_tbl_en(sa_tbl_en),
    .link_fdx(link_fdx), .rx_fc_en(rx_fc_en), .ucast_pause_en(ucast_pause_en),
    .res_vld(res_vld), .res_pass(res_pass), .res_da_fail(res_da_fail),
    .res_sa_fail(res_sa_fail), .res_ctl(res_ctl), .res_pause(res_pause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // watchdog and cycle count
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      finish_run();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (res_vld) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, "R1", {e.tag, " strobe cycle"}, cyc, e.cyc);
          chk(res_pass == e.pass, e.tag, "pass", res_pass, e.pass);
          chk(res_da_fail == e.daf, e.tag, "da_fail", res_da_fail, e.daf);
          chk(res_sa_fail == e.saf, e.tag, "sa_fail", res_sa_fail, e.saf);
          chk(res_ctl == e.ctl, e.tag, "ctl", res_ctl, e.ctl);
          chk(res_pause == e.pau, e.tag, "pause", res_pause, e.pau);
        end
      end else begin
        chk({res_pass, res_da_fail, res_sa_fail, res_ctl, res_pause} == 5'b0, "R12",
            "idle outputs", int'({res_pass, res_da_fail, res_sa_fail, res_ctl, res_pause}), 0);
      end
    end
  end

  task automatic frame(input logic [31:0] c, input logic [47:0] da, input logic [47:0] sa,
                       input logic [15:0] ty, input logic [15:0] op,
                       input bit f, input bit fc, input bit up,
                       input bit ep, input bit ed, input bit es, input bit ec, input bit epz,
                       input string tag, input int pay, input int gap_at);
    logic [127:0] hv;
    exp_t e;
    hv = {da, sa, ty, op};
    @(negedge clk);
    filt_cfg = c; link_fdx = f; rx_fc_en = fc; ucast_pause_en = up;
    for (int i = 0; i < 16; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        hdr_vld = 1'b0; hdr_sof = 1'b0;
      end
      @(negedge clk);
      if (i == 15) begin
        e.pass = ep; e.daf = ed; e.saf = es; e.ctl = ec; e.pau = epz;
        e.cyc = cyc + 1; e.tag = tag;
        q.push_back(e);
      end
      hdr_vld = 1'b1; hdr_sof = (i == 0); hdr_byte = hv[127-8*i -: 8];
    end
    for (int k = 0; k < pay; k++) begin
      @(negedge clk);
      hdr_vld = 1'b1; hdr_sof = 1'b0; hdr_byte = 8'(k * 37 + 5);
    end
    @(negedge clk);
    hdr_vld = 1'b0; hdr_sof = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic partial(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdr_vld = 1'b1; hdr_sof = (i == 0); hdr_byte = 8'hFF;
    end
    @(negedge clk);
    hdr_vld = 1'b0; hdr_sof = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; hdr_sof = 1'b0; hdr_vld = 1'b0; hdr_byte = 8'h00;
    filt_cfg = 32'h0; stn_addr = STA;
    sa_tbl = {SA_X ^ 48'h1, SA_C, SA_B, SA_A};
    sa_tbl_en = 4'b0011;
    link_fdx = 1'b1; rx_fc_en = 1'b1; ucast_pause_en = 1'b0;
    repeat (4) @(negedge clk);
    chk({res_vld, res_pass, res_da_fail, res_sa_fail, res_ctl, res_pause} == 6'b0, "R12",
        "outputs in reset", int'(res_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1;

    //     cfg            da    sa    type  op     fd fc up  pass daf saf ctl pau
    frame(32'h0,          STA,  SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R2 match", 0, 99);
    frame(32'h0,          OTH,  SA_A, TIP,  16'h0, 1, 1, 0,  0, 1, 0, 0, 0, "R2 mismatch", 0, 99);
    frame(32'h0,          STA,  SA_X, TIP,  16'h0, 1, 1, 0,  1, 0, 1, 0, 0, "R7 status only", 0, 99);
    frame(C_SAF,          STA,  SA_X, TIP,  16'h0, 1, 1, 0,  0, 0, 1, 0, 0, "R7 sa drop", 0, 99);
    frame(C_SAF,          STA,  SA_C, TIP,  16'h0, 1, 1, 0,  0, 0, 1, 0, 0, "R6 disabled entry", 0, 99);
    frame(C_SAF,          STA,  SA_B, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R6 entry1 hit", 0, 99);
    frame(C_SAI | C_SAF,  STA,  SA_B, TIP,  16'h0, 1, 1, 0,  0, 0, 1, 0, 0, "R6 inverse hit", 0, 99);
    frame(C_SAI,          STA,  SA_X, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R6 inverse miss", 0, 99);
    frame(C_DAI,          STA,  SA_A, TIP,  16'h0, 1, 1, 0,  0, 1, 0, 0, 0, "R3 inverse match", 0, 99);
    frame(C_DAI,          OTH,  SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R3 inverse miss", 0, 99);
    frame(32'h0,          MC,   SA_A, TIP,  16'h0, 1, 1, 0,  0, 1, 0, 0, 0, "R4 mcast no match", 0, 99);
    frame(C_PAM,          MC,   SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R4 pass all mcast", 0, 99);
    frame(C_DAI,          MC,   SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R3 inverse mcast", 0, 99);
    frame(32'h0,          BC,   SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R5 bcast pass", 0, 99);
    frame(C_DBF|C_PROM|C_RA, BC, SA_A, TIP, 16'h0, 1, 1, 0,  0, 0, 0, 0, 0, "R5 bcast block", 0, 99);
    frame(C_PROM,         OTH,  SA_X, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R8 promiscuous", 0, 99);
    frame(C_RA,           OTH,  SA_X, TIP,  16'h0, 1, 1, 0,  1, 1, 1, 0, 0, "R9 receive all", 0, 99);
    frame(32'h0,          PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  0, 1, 0, 1, 1, "R10 policy 00", 0, 99);
    frame(C_P01,          PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  0, 1, 0, 1, 1, "R10 policy 01 pause", 0, 99);
    frame(C_P10,          PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  1, 1, 0, 1, 1, "R10 policy 10", 0, 99);
    frame(C_P11,          PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  0, 1, 0, 1, 1, "R10 policy 11 fail", 0, 99);
    frame(C_P11 | C_PAM,  PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  1, 0, 0, 1, 1, "R10 policy 11 pass", 0, 99);
    frame(C_P01,          PMC,  SA_A, TCTL, 16'h2, 1, 1, 0,  1, 1, 0, 1, 0, "R11 opcode", 0, 99);
    frame(C_P01,          PMC,  SA_A, TCTL, 16'h1, 0, 1, 0,  1, 1, 0, 1, 0, "R11 half duplex", 0, 99);
    frame(C_P01,          PMC,  SA_A, TCTL, 16'h1, 1, 0, 0,  1, 1, 0, 1, 0, "R11 fc off", 0, 99);
    frame(C_P01,          STA,  SA_A, TCTL, 16'h1, 1, 1, 0,  1, 0, 0, 1, 0, "R11 unicast off", 0, 99);
    frame(C_P01,          STA,  SA_A, TCTL, 16'h1, 1, 1, 1,  0, 0, 0, 1, 1, "R11 unicast on", 0, 99);
    frame(C_RA,           PMC,  SA_A, TCTL, 16'h1, 1, 1, 0,  1, 1, 0, 1, 1, "R9 beats policy", 0, 99);

    // R1: truncated header, gaps, payload after header
    partial(9);
    frame(32'h0,          STA,  SA_A, TIP,  16'h0, 1, 1, 0,  1, 0, 0, 0, 0, "R1 after truncation", 20, 99);
    frame(32'h0,          OTH,  SA_B, TIP,  16'h0, 1, 1, 0,  0, 1, 0, 0, 0, "R1 gap in header", 5, 7);

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R1", "missing strobes", q.size(), 0);
    finish_run();
  end

endmodule